// File: doc/BRIEF.md
# Prescaled Multi-Mode Compare Timer

This block is an up counter that advances through a programmable prescaler and is compared against a programmable match value. Each time the counter reaches the match value, a time-out flag is raised. The flag can drive an interrupt line. The counter works in one of four modes, chosen by a two-bit selector: one-shot, periodic, toggle-output and free-running. The counter is clocked either by every timer clock cycle or by edges on an external event input, and the edge polarity is selectable.

Software-style control arrives as single-cycle write strobes with data alongside them:
- a prescale write;
- a match-value write;
- an enable write;
- a counter-reset command;
- a write-one-to-clear of the flag.

The mode, interrupt enable, event selection and edge polarity are static level inputs. An enable change passes through a two-stage synchroniser before counting starts or stops, and the `active` output shows when it has taken effect. The live count is always visible on `count`.

Top module: `prescaled_timer`

## Requirements
- R1: After reset, `tof`, `irq`, `tgl_out` and `active` are 0, and `count` is 0.
- R2: An enable write reaches `active` two clock edges after the edge that registers it. While `active` is 0 the count holds its value. When counting is re-enabled, it resumes from the held value.
- R3: With prescale value P, the counter advances once every P+1 source ticks. A prescale write clears both the prescale divider and the count.
- R4: The flag `tof` rises on the edge at which the count would reach the match value M. With the counter started from 0, this is (P+1)·M active ticks after counting starts. Asserting `tof_clr` clears the flag. If a match and `tof_clr` fall on the same edge, the flag stays set.
- R5: `irq` is 1 exactly when `tof` is 1 and `irq_en` is 1.
- R6: Mode 2'b00 (one-shot): on a match the count returns to 0 and the enable is dropped on that same edge. `active` is therefore 0 in the cycle the flag rises, and the count stays 0 afterwards.
- R7: Mode 2'b01 (periodic): on a match the count returns to 0 and counting continues, so matches repeat every (P+1)·M ticks.
- R8: Mode 2'b10 (toggle-output): the count behaves as in periodic mode, and `tgl_out` inverts on every match.
- R9: Mode 2'b11 (free-running): a match sets the flag, but the count keeps incrementing past the match value and wraps at 2^24.
- R10: A match-value write restarts the count and the prescaler from 0 in modes 00, 01 and 10. In mode 11 the same write leaves the count running undisturbed.
- R11: A `cnt_rst` pulse clears the count, the prescaler and the enable on the next edge, so `active` is 0 after that edge.
- R12: With `evt_mode`=1, a source tick is an edge on `evt_in`. With `evt_rise`=1 the tick is a rising edge; with `evt_rise`=0 it is a falling edge. Edges of the other polarity do not advance the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | 2 | Counting mode: 00 one-shot, 01 periodic, 10 toggle, 11 free-running |
| irq_en | input | 1 | Interrupt enable |
| evt_mode | input | 1 | 1 = count edges on `evt_in`, 0 = count clock cycles |
| evt_rise | input | 1 | Event polarity: 1 rising edge, 0 falling edge |
| evt_in | input | 1 | External event input |
| psc_wr | input | 1 | Prescale write strobe |
| psc_data | input | 8 | Prescale value P |
| cmp_wr | input | 1 | Match-value write strobe |
| cmp_data | input | 24 | Match value M (values 0 and 1 are illegal) |
| en_wr | input | 1 | Enable write strobe |
| en_data | input | 1 | Requested enable state |
| cnt_rst | input | 1 | Counter reset command |
| tof_clr | input | 1 | Write-one-to-clear of the time-out flag |
| tof | output | 1 | Time-out flag |
| irq | output | 1 | Interrupt request |
| tgl_out | output | 1 | Toggle output |
| active | output | 1 | Synchronised enable status |
| count | output | 24 | Live counter value |

## Verification
Two functions can land on the same clock edge: a counter match setting the time-out flag, and a software clear of that flag. The bench runs periodic mode with a match value of 3, so matches fall on a known edge. It raises `tof_clr` once off that edge, where the flag must fall, and once exactly on it, where the flag must stay set and the count must read 0. A design that let the clear win, or that lost the match, shows the wrong flag level one cycle after that edge.

// File: rtl/tmr_pkg.sv
// Shared types for the prescaled compare timer.
package tmr_pkg;
    typedef enum logic [1:0] {
        MD_ONESHOT  = 2'b00,
        MD_PERIODIC = 2'b01,
        MD_TOGGLE   = 2'b10,
        MD_FREERUN  = 2'b11
    } tmr_mode_e;
endpackage

// File: rtl/tmr_enable_sync.sv
// Enable request register plus a synchroniser chain. Active reflects the
// request SYNC_STAGES edges later. Assumes kill has priority over writes.
module tmr_enable_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_wr,
    input  logic en_data,
    input  logic kill,
    output logic active
);
    logic                   en_req;
    logic [SYNC_STAGES-1:0] sh;

    // Hold the requested enable; clear everything at once on a kill.
    always_ff @(posedge clk) begin
        if (!rst_n || kill) begin
            en_req <= 1'b0;
            sh     <= '0;
        end else begin
            if (en_wr) en_req <= en_data;
            sh <= {sh[SYNC_STAGES-2:0], en_req};
        end
    end

    assign active = sh[SYNC_STAGES-1];

    p_active_lag_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(active) |-> $past(en_req, SYNC_STAGES))
        else $error("active rose without an earlier request");
endmodule

// File: rtl/tmr_tick_gen.sv
// Source tick selection (clock or event edge) and prescale divider.
// Emits one step every PSC+1 ticks while active. Assumes evt_in is synchronous.
module tmr_tick_gen #(
    parameter int PSC_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             evt_mode,
    input  logic             evt_rise,
    input  logic             evt_in,
    input  logic             psc_wr,
    input  logic [PSC_W-1:0] psc_data,
    input  logic             restart,
    output logic             step
);
    logic             evt_d;
    logic             evt_edge;
    logic             adv;
    logic [PSC_W-1:0] psc_q;
    logic [PSC_W-1:0] pcnt;

    // Remember the previous event level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_d <= 1'b0;
        else        evt_d <= evt_in;
    end

    // Pick the tick source and the divider terminal step.
    always_comb begin
        evt_edge = evt_rise ? (evt_in & ~evt_d) : (~evt_in & evt_d);
        adv      = active & (evt_mode ? evt_edge : 1'b1);
        step     = adv & (pcnt == psc_q);
    end

    // Prescale register and divider count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            psc_q <= '0;
            pcnt  <= '0;
        end else begin
            if (psc_wr) psc_q <= psc_data;
            if (psc_wr || restart) pcnt <= '0;
            else if (adv)          pcnt <= step ? '0 : pcnt + 1'b1;
        end
    end

    p_step_needs_active_r2: assert property (@(posedge clk) disable iff (!rst_n)
        step |-> active)
        else $error("step while inactive");
endmodule

// File: rtl/tmr_core.sv
// Up counter, match register, flag and toggle with mode-dependent reload.
// Assumes the match value is never 0 or 1.
module tmr_core
    import tmr_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  tmr_mode_e        mode,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_data,
    input  logic             cnt_clr,
    input  logic             flag_clr,
    output logic             cmp_restart,
    output logic             os_hit,
    output logic [CNT_W-1:0] cnt,
    output logic             tof,
    output logic             tgl
);
    localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

    logic [CNT_W-1:0] cmp_q;
    logic [CNT_W-1:0] nxt;
    logic             hit_eff;

    // Decode match and restart conditions.
    always_comb begin
        nxt         = cnt + ONE;
        cmp_restart = cmp_wr && (mode != MD_FREERUN);
        hit_eff     = step && (nxt == cmp_q) && !cnt_clr && !cmp_restart;
        os_hit      = hit_eff && (mode == MD_ONESHOT);
    end

    // Match value register.
    always_ff @(posedge clk) begin
        if (!rst_n)      cmp_q <= '1;
        else if (cmp_wr) cmp_q <= cmp_data;
    end

    // Counter with reload to 0 on match except in free-running mode.
    always_ff @(posedge clk) begin
        if (!rst_n || cnt_clr || cmp_restart) cnt <= '0;
        else if (step) cnt <= (hit_eff && mode != MD_FREERUN) ? '0 : nxt;
    end

    // Flag: a match beats a clear on the same edge.
    always_ff @(posedge clk) begin
        if (!rst_n)        tof <= 1'b0;
        else if (hit_eff)  tof <= 1'b1;
        else if (flag_clr) tof <= 1'b0;
    end

    // Toggle output flips on each match in toggle mode.
    always_ff @(posedge clk) begin
        if (!rst_n)                               tgl <= 1'b0;
        else if (hit_eff && mode == MD_TOGGLE)    tgl <= ~tgl;
    end

    p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        hit_eff |=> tof)
        else $error("match did not set flag");
    p_flag_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        flag_clr && !hit_eff |=> !tof)
        else $error("flag not cleared");
    p_reload_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        hit_eff && (mode == MD_PERIODIC || mode == MD_TOGGLE) |=> cnt == '0)
        else $error("no reload on match");
    p_freerun_keep_r10: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_wr && mode == MD_FREERUN && !cnt_clr |=> (cnt - $past(cnt)) <= ONE)
        else $error("match write disturbed free-running count");
endmodule

// File: rtl/prescaled_timer.sv
// Top of the prescaled multi-mode compare timer. Wires the enable
// synchroniser, tick generator and counter core. Inputs are synchronous to clk.
module prescaled_timer
    import tmr_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int PSC_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       mode_sel,
    input  logic             irq_en,
    input  logic             evt_mode,
    input  logic             evt_rise,
    input  logic             evt_in,
    input  logic             psc_wr,
    input  logic [PSC_W-1:0] psc_data,
    input  logic             cmp_wr,
    input  logic [CNT_W-1:0] cmp_data,
    input  logic             en_wr,
    input  logic             en_data,
    input  logic             cnt_rst,
    input  logic             tof_clr,
    output logic             tof,
    output logic             irq,
    output logic             tgl_out,
    output logic             active,
    output logic [CNT_W-1:0] count
);
    tmr_mode_e mode;
    logic      step;
    logic      os_hit;
    logic      cmp_restart;
    logic      kill;
    logic      div_restart;
    logic      cnt_clr;

    // Combine the control strobes into clear and kill terms.
    always_comb begin
        mode        = tmr_mode_e'(mode_sel);
        kill        = cnt_rst | os_hit;
        cnt_clr     = cnt_rst | psc_wr;
        div_restart = cnt_rst | cmp_restart;
        irq         = tof & irq_en;
    end

    tmr_enable_sync #(.SYNC_STAGES(SYNC_STAGES)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_wr   (en_wr),
        .en_data (en_data),
        .kill    (kill),
        .active  (active)
    );

    tmr_tick_gen #(.PSC_W(PSC_W)) u_tick (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .evt_mode (evt_mode),
        .evt_rise (evt_rise),
        .evt_in   (evt_in),
        .psc_wr   (psc_wr),
        .psc_data (psc_data),
        .restart  (div_restart),
        .step     (step)
    );

    tmr_core #(.CNT_W(CNT_W)) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (step),
        .mode        (mode),
        .cmp_wr      (cmp_wr),
        .cmp_data    (cmp_data),
        .cnt_clr     (cnt_clr),
        .flag_clr    (tof_clr),
        .cmp_restart (cmp_restart),
        .os_hit      (os_hit),
        .cnt         (count),
        .tof         (tof),
        .tgl         (tgl_out)
    );

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !active && !cnt_rst && !psc_wr && !cmp_wr |=> $stable(count))
        else $error("count moved while inactive");
    p_oneshot_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        os_hit |=> !active)
        else $error("one-shot did not stop");
    p_rst_cmd_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_rst |=> (count == '0) && !active)
        else $error("reset command incomplete");
endmodule

// File: tb/prescaled_timer_tb.sv
`timescale 1ns/1ps
module prescaled_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  mode_sel = 2'b01;
    logic        irq_en = 1'b1;
    logic        evt_mode = 1'b0;
    logic        evt_rise = 1'b1;
    logic        evt_in = 1'b0;
    logic        psc_wr = 1'b0;
    logic [7:0]  psc_data = '0;
    logic        cmp_wr = 1'b0;
    logic [23:0] cmp_data = '0;
    logic        en_wr = 1'b0;
    logic        en_data = 1'b0;
    logic        cnt_rst = 1'b0;
    logic        tof_clr = 1'b0;
    logic        tof, irq, tgl_out, active;
    logic [23:0] count;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    prescaled_timer u_dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .irq_en(irq_en),
        .evt_mode(evt_mode), .evt_rise(evt_rise), .evt_in(evt_in),
        .psc_wr(psc_wr), .psc_data(psc_data), .cmp_wr(cmp_wr), .cmp_data(cmp_data),
        .en_wr(en_wr), .en_data(en_data), .cnt_rst(cnt_rst), .tof_clr(tof_clr),
        .tof(tof), .irq(irq), .tgl_out(tgl_out), .active(active), .count(count)
    );

    // Vector table: prescale, match, mode, edges from enable edge to flag.
    localparam int NV = 6;
    localparam int V_PSC [NV] = '{0, 3, 1, 0, 7, 2};
    localparam int V_CMP [NV] = '{5, 4, 10, 2, 3, 6};
    localparam int V_MOD [NV] = '{1, 0, 2, 3, 1, 0};
    localparam int V_EXP [NV] = '{7, 18, 22, 4, 26, 20};

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step(int n = 1);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic setup(int p, int c, int m, logic ev = 1'b0, logic rise = 1'b1);
        cnt_rst = 1'b1; tof_clr = 1'b1;
        step();
        cnt_rst = 1'b0; tof_clr = 1'b0;
        mode_sel = m[1:0]; evt_mode = ev; evt_rise = rise;
        psc_wr = 1'b1; psc_data = p[7:0]; cmp_wr = 1'b1; cmp_data = c[23:0];
        step();
        psc_wr = 1'b0; cmp_wr = 1'b0;
        en_wr = 1'b1; en_data = 1'b1;
        step();
        en_wr = 1'b0;
    endtask

    task automatic wait_tof(output int n);
        n = 0;
        while (!tof && n < 3000) begin
            step();
            n++;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int n;
        int t0;
        step(3);
        rst_n = 1'b1;
        step();
        // R1 reset state
        chk("R1 tof", tof, 0);
        chk("R1 irq", irq, 0);
        chk("R1 tgl_out", tgl_out, 0);
        chk("R1 active", active, 0);
        chk("R1 count", count, 0);

        // Table walk: R3/R4 timing, then a mode-specific check
        for (int i = 0; i < NV; i++) begin
            setup(V_PSC[i], V_CMP[i], V_MOD[i]);
            wait_tof(n);
            chk("R3 R4 time-out edges", n, V_EXP[i]);
            case (V_MOD[i])
                0: begin
                    chk("R6 active dropped", active, 0);
                    step(4);
                    chk("R6 count stays 0", count, 0);
                end
                1: chk("R7 count reloaded", count, 0);
                2: chk("R8 toggle after match", tgl_out, 1);
                default: begin
                    chk("R9 count at match", count, V_CMP[i]);
                    step(3);
                    chk("R9 count continues", count, V_CMP[i] + 3);
                end
            endcase
        end

        // Same-edge match and clear (R4), periodic repeat (R7), irq gating (R5)
        irq_en = 1'b1;
        setup(0, 3, 1);
        wait_tof(n);
        chk("R4 first match", n, 5);
        chk("R5 irq high", irq, 1);
        tof_clr = 1'b1; step(); tof_clr = 1'b0;
        chk("R4 clear", tof, 0);
        step();
        tof_clr = 1'b1; step(); tof_clr = 1'b0;
        chk("R4 match wins over clear", tof, 1);
        chk("R7 reload on repeat", count, 0);
        irq_en = 1'b0; #1;
        chk("R5 irq masked", irq, 0);
        irq_en = 1'b1;

        // Toggle output inverts on every match (R8)
        setup(0, 3, 2);
        t0 = tgl_out;
        wait_tof(n);
        chk("R8 first invert", tgl_out, t0 ^ 1);
        step(3);
        chk("R8 second invert", tgl_out, t0);

        // Match write restarts outside free-running (R10)
        setup(0, 20, 1);
        step(10);
        chk("R10 count before write", count, 8);
        cmp_wr = 1'b1; cmp_data = 24'd30; step(); cmp_wr = 1'b0;
        chk("R10 restart periodic", count, 0);
        step(5);
        chk("R10 counting after restart", count, 5);
        setup(0, 20, 3);
        step(10);
        cmp_wr = 1'b1; cmp_data = 24'd30; step(); cmp_wr = 1'b0;
        chk("R10 free-running undisturbed", count, 9);

        // Prescale write clears count (R3); enable lag and hold (R2)
        psc_wr = 1'b1; psc_data = 8'd0; step(); psc_wr = 1'b0;
        chk("R3 prescale write clears", count, 0);
        en_wr = 1'b1; en_data = 1'b0; step(); en_wr = 1'b0;
        chk("R2 still active after 1 edge", active, 1);
        step();
        chk("R2 count while draining", count, 2);
        step();
        chk("R2 inactive after 2 edges", active, 0);
        chk("R2 last count", count, 3);
        step(5);
        chk("R2 count held", count, 3);
        en_wr = 1'b1; en_data = 1'b1; step(); en_wr = 1'b0;
        chk("R2 not yet active", active, 0);
        step(2);
        chk("R2 active again", active, 1);
        chk("R2 resume from held", count, 3);
        step();
        chk("R2 resumed", count, 4);

        // Counter reset command (R11)
        cnt_rst = 1'b1; step(); cnt_rst = 1'b0;
        chk("R11 count cleared", count, 0);
        chk("R11 active cleared", active, 0);

        // Event counting, rising then falling polarity (R12)
        setup(0, 100, 3, 1'b1, 1'b1);
        step(2);
        repeat (3) begin
            evt_in = 1'b1; step(2);
            evt_in = 1'b0; step(2);
        end
        chk("R12 rising edges counted", count, 3);
        cnt_rst = 1'b1; step(); cnt_rst = 1'b0;
        evt_rise = 1'b0;
        en_wr = 1'b1; en_data = 1'b1; step(); en_wr = 1'b0;
        step(2);
        evt_in = 1'b1; step(2);
        chk("R12 rising ignored when falling selected", count, 0);
        evt_in = 1'b0; step();
        chk("R12 falling edge counted", count, 1);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule